// File: doc/BRIEF.md
# Shift Rotate Mask Unit

This is a combinational integer execution unit for a 64-bit datapath. Each evaluation takes one operation and produces its result directly. The operations are:

- a logical left shift;
- a logical or arithmetic right shift;
- a left shift that first sign-extends the low word;
- a 32-bit rotate whose result is merged with a second operand under a begin/end bit mask.

A mode flag narrows the shifts to the low 32-bit word. A tag supplied with the operation comes back out unchanged, so the issuing logic can match results to operations.

Bit positions for the mask count from the most significant end. Position p is result bit 63-p. The mask may wrap around: when the begin position lies past the end position, the selected region runs from begin to the top position and continues from position 0 to end.

Top module: `srm_unit`

## Requirements
- R1: With opcode 1 (left shift) and mode32=1, the shift count is amt_word[5:0]; result[31:0] is src_word[31:0] shifted left and truncated to 32 bits, and result[63:32] is zero, so counts of 32 to 63 give zero.
- R2: With opcode 1 and mode32=0, the count is amt_word[6:0]; result is src_word shifted left, truncated to 64 bits, so counts of 64 to 127 give zero. amt_word[63:7] has no effect.
- R3: With opcode 2 and is_signed=0 (logical right shift), mode32=1 gives result[31:0] = src_word[31:0] >> amt_word[5:0] with result[63:32] zero; mode32=0 gives src_word >> amt_word[6:0].
- R4: With opcode 2 and is_signed=1 (arithmetic right shift), mode32=1 shifts src_word[31:0] as a signed word by amt_word[5:0] and fills result[63:32] with src_word[31]; mode32=0 shifts src_word as signed by amt_word[6:0], so counts of 64 to 127 give 64 copies of src_word[63].
- R5: With opcode 3 and mode32=0, src_word[31:0] is sign-extended to 64 bits and shifted left by amt_word[6:0], truncated to 64 bits; with mode32=1 opcode 3 gives the same result as R1.
- R6: With opcode 4, src_word[31:0] is rotated left by amt_word[5:0] modulo 32 into bits 31:0 of a 64-bit rotated word whose bits 63:32 are zero; mode32 and is_signed have no effect on the result.
- R7: The opcode 4 mask has a begin part set at positions mask_begin..63 and an end part set at positions 0..mask_end (positions 64 to 127 do not exist; position p is bit 63-p). The mask is the OR of the parts when mask_begin > mask_end, and their AND otherwise.
- R8: With opcode 4, result = (rotated AND mask) OR (ins_word AND NOT mask).
- R9: result_vld is 1 for opcodes 1 to 4; for opcodes 0, 5, 6 and 7, result_vld is 0 and result is zero.
- R10: tag_out equals tag_in for every opcode.
- R11: A shift count of zero returns the source unchanged for opcodes 1 and 2 in 64-bit mode, and returns the sign-extended low word for opcode 3 in 64-bit mode.
- R12: For opcodes 1 to 3, ins_word, mask_begin and mask_end have no effect; is_signed affects only opcode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_word | input | 64 | Word to be shifted or rotated |
| amt_word | input | 64 | Shift or rotate count; only the low bits are used |
| ins_word | input | 64 | Word supplying the bits outside the rotate mask |
| opcode | input | 3 | 0 idle, 1 left shift, 2 right shift, 3 sign-extend then left shift, 4 rotate and mask |
| mask_begin | input | 7 | First mask position, counted from the most significant bit |
| mask_end | input | 7 | Last mask position, counted from the most significant bit |
| is_signed | input | 1 | Selects arithmetic right shift for opcode 2 |
| mode32 | input | 1 | Restricts shifts to the low 32-bit word |
| tag_in | input | TAG_W | Context tag for the operation |
| result | output | 64 | Operation result |
| result_vld | output | 1 | High when the opcode is recognised |
| tag_out | output | TAG_W | Copy of tag_in |

## Verification
The unit holds no state, so any internal fault shows up in result in the same evaluation as the input that exercises it. A fault on the wrong path stays invisible until that path is selected.

- A fault in the mask generator shows only under opcode 4, and only in bits where ins_word and the rotated word differ. That is why the stimulus draws both the insert word and the begin/end pair at random, with wrapped and unwrapped pairs.
- A fault in count truncation shows only for counts at or above 32 or 64.
- A fault in the sign fill shows only for sources whose sign bit is set.

The directed cases place counts on those edges.

// File: rtl/srm_pkg.sv
`timescale 1ns/1ps
package srm_pkg;
  localparam int DW     = 64;
  localparam int HW     = DW / 2;
  localparam int AMT_W  = $clog2(DW) + 1;
  localparam int SH32_W = $clog2(HW) + 1;
  localparam int ROT_W  = $clog2(HW);
  localparam int POS_W  = AMT_W;

  typedef enum logic [2:0] {
    OPC_IDLE = 3'd0,
    OPC_SLL  = 3'd1,
    OPC_SRX  = 3'd2,
    OPC_SXSL = 3'd3,
    OPC_ROTM = 3'd4
  } srm_op_e;

  // left shift, narrowed to the low word in 32-bit mode
  function automatic logic [DW-1:0] f_shl(logic [DW-1:0] v, logic [AMT_W-1:0] n, logic m32);
    logic [DW-1:0] t;
    if (m32) begin
      t = {{HW{1'b0}}, v[HW-1:0]} << n[SH32_W-1:0];
      return {{HW{1'b0}}, t[HW-1:0]};
    end
    return v << n;
  endfunction

  // right shift, logical or arithmetic
  function automatic logic [DW-1:0] f_shr(logic [DW-1:0] v, logic [AMT_W-1:0] n,
                                          logic m32, logic sgn);
    logic signed [HW-1:0] lo_s;
    logic signed [DW-1:0] full_s;
    logic [HW-1:0]        lo;
    if (m32) begin
      if (sgn) begin
        lo_s = v[HW-1:0];
        lo   = lo_s >>> n[SH32_W-1:0];
        return {{HW{v[HW-1]}}, lo};
      end
      lo = v[HW-1:0] >> n[SH32_W-1:0];
      return {{HW{1'b0}}, lo};
    end
    if (sgn) begin
      full_s = v;
      return full_s >>> n;
    end
    return v >> n;
  endfunction

  // sign-extend low word, then shift left
  function automatic logic [DW-1:0] f_sxshl(logic [DW-1:0] v, logic [AMT_W-1:0] n, logic m32);
    if (m32) return f_shl(v, n, 1'b1);
    return {{HW{v[HW-1]}}, v[HW-1:0]} << n;
  endfunction

  // 32-bit rotate left via a doubled word
  function automatic logic [HW-1:0] f_rotl(logic [HW-1:0] x, logic [ROT_W-1:0] r);
    logic [DW-1:0] t;
    t = {x, x} << r;
    return t[DW-1:HW];
  endfunction
endpackage

// File: rtl/srm_mask_gen.sv
`timescale 1ns/1ps
module srm_mask_gen
  import srm_pkg::*;
(
  input  logic [POS_W-1:0] mb,
  input  logic [POS_W-1:0] me,
  output logic [DW-1:0]    begin_mask,
  output logic [DW-1:0]    end_mask,
  output logic             wrap,
  output logic [DW-1:0]    mask
);
  // bit i of the word is position DW-1-i counted from the top
  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam logic [POS_W-1:0] POS = POS_W'(DW - 1 - i);
    assign begin_mask[i] = (mb <= POS);
    assign end_mask[i]   = (POS <= me);
  end

  assign wrap = (mb > me);
  assign mask = wrap ? (begin_mask | end_mask) : (begin_mask & end_mask);

  always_comb begin
    if (!wrap && me < POS_W'(DW)) begin
      a_r7_plain_count: assert ($countones(mask) == int'(me) - int'(mb) + 1)
        else $error("mask width mismatch in plain range");
    end
    if (wrap && mb < POS_W'(DW)) begin
      a_r7_wrap_count: assert ($countones(mask) == DW - int'(mb) + int'(me) + 1)
        else $error("mask width mismatch in wrapped range");
    end
  end
endmodule

// File: rtl/srm_shifter.sv
`timescale 1ns/1ps
module srm_shifter
  import srm_pkg::*;
(
  input  logic [DW-1:0]    src,
  input  logic [AMT_W-1:0] amt,
  input  logic             m32,
  input  logic             sgn,
  output logic [DW-1:0]    shl_res,
  output logic [DW-1:0]    shr_res,
  output logic [DW-1:0]    sxl_res
);
  assign shl_res = f_shl(src, amt, m32);
  assign shr_res = f_shr(src, amt, m32, sgn);
  assign sxl_res = f_sxshl(src, amt, m32);

  always_comb begin
    if (amt == '0 && !m32) begin
      a_r11_zero_count: assert (shl_res == src && shr_res == src)
        else $error("zero count altered source");
    end
    if (!m32 && sgn) begin
      a_r4_sign_kept: assert (shr_res[DW-1] == src[DW-1])
        else $error("arithmetic shift lost sign");
    end
    if (m32) begin
      a_r5_narrow_same: assert (sxl_res == shl_res)
        else $error("narrow sign-extend shift differs from left shift");
    end
  end
endmodule

// File: rtl/srm_rotator.sv
`timescale 1ns/1ps
module srm_rotator
  import srm_pkg::*;
(
  input  logic [HW-1:0]    word,
  input  logic [ROT_W-1:0] sh,
  output logic [DW-1:0]    rot
);
  logic [HW-1:0] rot_lo;
  assign rot_lo = f_rotl(word, sh);
  assign rot    = {{HW{1'b0}}, rot_lo};

  always_comb begin
    a_r6_ones_kept: assert ($countones(rot) == $countones(word))
      else $error("rotate changed population count");
    if (sh == '0) begin
      a_r6_zero_rot: assert (rot_lo == word)
        else $error("zero rotate altered word");
    end
  end
endmodule

// File: rtl/srm_unit.sv
`timescale 1ns/1ps
module srm_unit
  import srm_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [63:0]      src_word,
  input  logic [63:0]      amt_word,
  input  logic [63:0]      ins_word,
  input  logic [2:0]       opcode,
  input  logic [6:0]       mask_begin,
  input  logic [6:0]       mask_end,
  input  logic             is_signed,
  input  logic             mode32,
  input  logic [TAG_W-1:0] tag_in,
  output logic [63:0]      result,
  output logic             result_vld,
  output logic [TAG_W-1:0] tag_out
);
  logic [DW-1:0] shl_res, shr_res, sxl_res, rot_res;
  logic [DW-1:0] begin_mask, end_mask, mask, merged;
  logic          wrap;
  logic          unused_amt_hi;

  assign unused_amt_hi = ^amt_word[DW-1:AMT_W];

  srm_shifter u_shift (
    .src     (src_word),
    .amt     (amt_word[AMT_W-1:0]),
    .m32     (mode32),
    .sgn     (is_signed),
    .shl_res (shl_res),
    .shr_res (shr_res),
    .sxl_res (sxl_res)
  );

  srm_rotator u_rot (
    .word (src_word[HW-1:0]),
    .sh   (amt_word[ROT_W-1:0]),
    .rot  (rot_res)
  );

  srm_mask_gen u_mask (
    .mb         (mask_begin),
    .me         (mask_end),
    .begin_mask (begin_mask),
    .end_mask   (end_mask),
    .wrap       (wrap),
    .mask       (mask)
  );

  assign merged = (rot_res & mask) | (ins_word & ~mask);

  always_comb begin
    result     = '0;
    result_vld = 1'b0;
    case (opcode)
      OPC_SLL:  begin result = shl_res; result_vld = 1'b1; end
      OPC_SRX:  begin result = shr_res; result_vld = 1'b1; end
      OPC_SXSL: begin result = sxl_res; result_vld = 1'b1; end
      OPC_ROTM: begin result = merged;  result_vld = 1'b1; end
      default:  ;
    endcase
  end

  assign tag_out = tag_in;

  always_comb begin
    if (!result_vld) begin
      a_r9_idle_zero: assert (result == '0)
        else $error("idle opcode produced data");
    end
    if (result_vld && opcode == OPC_SLL && mode32) begin
      a_r1_hi_zero: assert (result[DW-1:HW] == '0)
        else $error("narrow left shift leaked into upper word");
    end
    if (result_vld && opcode == OPC_SRX && mode32 && is_signed) begin
      a_r4_hi_fill: assert (result[DW-1:HW] == '0 || result[DW-1:HW] == '1)
        else $error("narrow arithmetic shift upper word not uniform");
    end
    if (opcode == OPC_ROTM) begin
      a_r8_merge_sel: assert (((result ^ rot_res) & mask) == '0 &&
                              ((result ^ ins_word) & ~mask) == '0)
        else $error("merge took a bit from the wrong source");
    end
  end
endmodule

// File: tb/test_srm_unit.sv
`timescale 1ns/1ps
module test_srm_unit;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic [63:0] src_word, amt_word, ins_word, result;
  logic [2:0]  opcode;
  logic [6:0]  mask_begin, mask_end;
  logic        is_signed, mode32, result_vld;
  logic [TW-1:0] tag_in, tag_out;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  srm_unit #(.TAG_W(TW)) i_srm_unit (
    .src_word, .amt_word, .ins_word, .opcode, .mask_begin, .mask_end,
    .is_signed, .mode32, .tag_in, .result, .result_vld, .tag_out
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] b_lsh(logic [63:0] v, int n, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = (i - n >= 0) ? v[i - n] : 1'b0;
    return r;
  endfunction

  function automatic logic [63:0] b_rsh(logic [63:0] v, int n, int w, logic fill);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = (i + n < w) ? v[i + n] : fill;
    return r;
  endfunction

  // returns {valid, result}
  function automatic logic [64:0] model(logic [2:0] op, logic [63:0] s, logic [63:0] a,
                                        logic [63:0] ins, logic [6:0] mb, logic [6:0] me,
                                        logic sg, logic m32);
    logic [63:0] r = '0;
    logic [63:0] rot = '0;
    logic [63:0] msk = '0;
    logic [63:0] sx;
    int n7 = int'(a[6:0]);
    int n6 = int'(a[5:0]);
    case (op)
      3'd1: r = m32 ? b_lsh(s, n6, 32) : b_lsh(s, n7, 64);
      3'd2: if (m32) begin
              r = b_rsh(s, n6, 32, sg & s[31]);
              if (sg) r[63:32] = {32{s[31]}};
            end else r = b_rsh(s, n7, 64, sg & s[63]);
      3'd3: begin
              sx = {{32{s[31]}}, s[31:0]};
              r  = m32 ? b_lsh(s, n6, 32) : b_lsh(sx, n7, 64);
            end
      3'd4: begin
              for (int i = 0; i < 32; i++) rot[i] = s[(i - (n6 % 32) + 32) % 32];
              for (int p = 0; p < 64; p++) begin
                logic bb = (p >= int'(mb));
                logic ee = (p <= int'(me));
                msk[63 - p] = (mb > me) ? (bb | ee) : (bb & ee);
              end
              r = (rot & msk) | (ins & ~msk);
            end
      default: r = '0;
    endcase
    return {(op >= 3'd1 && op <= 3'd4), r};
  endfunction

  function automatic string req_of(logic [2:0] op, logic sg, logic m32);
    case (op)
      3'd1: return m32 ? "R1" : "R2";
      3'd2: return sg ? "R4" : "R3";
      3'd3: return "R5";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(logic [2:0] op, logic [63:0] s, logic [63:0] a, logic [63:0] ins,
                       logic [6:0] mb, logic [6:0] me, logic sg, logic m32, logic [TW-1:0] tg);
    @(negedge clk);
    opcode = op; src_word = s; amt_word = a; ins_word = ins;
    mask_begin = mb; mask_end = me; is_signed = sg; mode32 = m32; tag_in = tg;
    @(posedge clk);
    #1;
  endtask

  task automatic run(string req, logic [2:0] op, logic [63:0] s, logic [63:0] a,
                     logic [63:0] ins, logic [6:0] mb, logic [6:0] me, logic sg,
                     logic m32, logic [TW-1:0] tg);
    logic [64:0] e;
    drive(op, s, a, ins, mb, me, sg, m32, tg);
    e = model(op, s, a, ins, mb, me, sg, m32);
    chk(req, result, e[63:0]);
    chk({req, " R9 valid"}, {63'd0, result_vld}, {63'd0, e[64]});
    chk("R10 tag", {{(64-TW){1'b0}}, tag_out}, {{(64-TW){1'b0}}, tg});
  endtask

  initial begin
    logic [63:0] r1, r2;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    opcode = '0; src_word = '0; amt_word = '0; ins_word = '0;
    mask_begin = '0; mask_end = '0; is_signed = 1'b0; mode32 = 1'b0; tag_in = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset result", result, 64'd0);
    chk("R9 reset valid", {63'd0, result_vld}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    run("R1 count31", 3'd1, 64'hFFFF_0000_8000_0003, 64'd31, 64'd0, 7'd0, 7'd0, 1'b0, 1'b1, 8'h11);
    run("R1 count32", 3'd1, 64'hFFFF_0000_8000_0003, 64'd32, 64'd0, 7'd0, 7'd0, 1'b0, 1'b1, 8'h12);
    run("R2 count63", 3'd1, 64'h0000_0000_0000_0001, 64'd63, 64'd0, 7'd0, 7'd0, 1'b0, 1'b0, 8'h13);
    run("R2 count64", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 64'd0, 7'd0, 7'd0, 1'b0, 1'b0, 8'h14);
    run("R2 high count bits", 3'd1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF01, 64'd0,
        7'd0, 7'd0, 1'b0, 1'b0, 8'h15);
    run("R3 narrow", 3'd2, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'd0, 7'd0, 7'd0, 1'b0, 1'b1, 8'h16);
    run("R4 narrow count40", 3'd2, 64'h0000_0000_8000_0000, 64'd40, 64'd0, 7'd0, 7'd0, 1'b1, 1'b1, 8'h17);
    run("R4 wide count100", 3'd2, 64'h8000_0000_0000_0000, 64'd100, 64'd0, 7'd0, 7'd0, 1'b1, 1'b0, 8'h18);
    run("R5 wide", 3'd3, 64'h0000_0000_F000_0001, 64'd4, 64'd0, 7'd0, 7'd0, 1'b0, 1'b0, 8'h19);
    run("R11 sxsl zero", 3'd3, 64'h1234_5678_8765_4321, 64'd0, 64'd0, 7'd0, 7'd0, 1'b0, 1'b0, 8'h1A);
    run("R11 shl zero", 3'd1, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, 64'd0, 7'd0, 7'd0, 1'b0, 1'b0, 8'h1B);
    run("R11 sra zero", 3'd2, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, 64'd0, 7'd0, 7'd0, 1'b1, 1'b0, 8'h1C);
    run("R6 rot zero full mask", 3'd4, 64'hAAAA_AAAA_1234_5678, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF,
        7'd32, 7'd63, 1'b0, 1'b1, 8'h1D);
    run("R6 rot 36", 3'd4, 64'h0, 64'd36, 64'h0, 7'd0, 7'd127, 1'b0, 1'b1, 8'h1E);
    run("R7 wrapped mask", 3'd4, 64'h0000_0000_8000_0001, 64'd1, 64'h5555_5555_5555_5555,
        7'd60, 7'd3, 1'b0, 1'b1, 8'h1F);
    run("R7 begin past top", 3'd4, 64'h0000_0000_FFFF_FFFF, 64'd0, 64'h0F0F_0F0F_0F0F_0F0F,
        7'd70, 7'd80, 1'b0, 1'b1, 8'h20);
    run("R9 op7", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1, 7'd1, 7'd2, 1'b1, 1'b0, 8'h21);
    run("R9 op5", 3'd5, 64'h1, 64'd1, 64'd1, 7'd1, 7'd2, 1'b0, 1'b1, 8'h22);

    // R6: mode and signed flags have no effect on the rotate
    drive(3'd4, 64'h0123_4567_89AB_CDEF, 64'd13, 64'hFEDC_BA98_7654_3210, 7'd40, 7'd50, 1'b0, 1'b1, 8'h23);
    r1 = result;
    drive(3'd4, 64'h0123_4567_89AB_CDEF, 64'd13, 64'hFEDC_BA98_7654_3210, 7'd40, 7'd50, 1'b1, 1'b0, 8'h23);
    r2 = result;
    chk("R6 flags ignored", r2, r1);

    // R12: insert word and mask fields have no effect on shifts
    drive(3'd1, 64'h0F0F_1234_5678_9ABC, 64'd9, 64'd0, 7'd0, 7'd0, 1'b0, 1'b0, 8'h24);
    r1 = result;
    drive(3'd1, 64'h0F0F_1234_5678_9ABC, 64'd9, 64'hFFFF_FFFF_FFFF_FFFF, 7'd5, 7'd9, 1'b1, 1'b0, 8'h24);
    r2 = result;
    chk("R12 shift ignores insert, mask, signed", r2, r1);

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [2:0]  op  = 3'($urandom % 8);
      logic [63:0] s   = {$urandom, $urandom};
      logic [63:0] a   = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 130);
      logic [63:0] ins = {$urandom, $urandom};
      logic [6:0]  mb  = ($urandom % 2 == 0) ? 7'(32 + $urandom % 32) : 7'($urandom);
      logic [6:0]  me  = ($urandom % 2 == 0) ? 7'(32 + $urandom % 32) : 7'($urandom);
      logic        sg  = 1'($urandom);
      logic        m32 = 1'($urandom);
      run(req_of(op, sg, m32), op, s, a, ins, mb, me, sg, m32, TW'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule